// File: doc/BRIEF.md
# Vertical linear-phase line interpolator

This block shrinks a pixel stream vertically by factors between one and one half. Every output line is a weighted mix of two neighbouring input lines. A phase accumulator advances by a programmable step for each output line, measured in 1/1024 of an input line. Its integer part picks the pair of lines, and six bits of its fraction give the blend weight in 1/64 steps. A start phase of 0 to 64 sixty-fourths of a line sets where the first output line sits.

Pixels arrive one per valid cycle, with a start-of-frame and a start-of-line marker. Three line stores hold recent lines in rotation. In normal operation the previous line is read back while the current one streams in, so an output pixel follows its input pixel by one cycle. A step of zero selects one of two fixed modes: a pass-through, or a two-line low-pass. In both, the first input line is copied out unchanged.

The mirror option emits each output line with its pixels reversed. Because a whole line must be stored before it can be reversed, each mirrored line is sent out while the next input line arrives. The output that would need the last line of the frame is therefore never emitted.

Top module: `vlerp_scaler`

## Requirements
- R1: After reset, `out_valid`, `out_sol`, `out_sof` and `err_trunc` are low.
- R2: Each output pixel equals (A*p1 + (64-A)*p0 + 32) >> 6 on 8-bit unsigned pixels, where p0 is the upper line of the pair, p1 the lower, and A runs from 0 to 64.
- R3: With a nonzero step, output line m lies at position start*16 + m*step in 1/1024-line units. Its pair is (floor(pos/1024), that line + 1) and A is bits [9:4] of pos. It is emitted while the pair's second line streams in, and only if that line exists in the frame.
- R4: A start phase of 0 puts the first output on input line 0 with A=0. A start phase of 64 puts it on input line 1.
- R5: With step 0 and start 64, every input line is copied to the output unchanged, so the output line count equals the input line count.
- R6: With step 0 and start below 64, input line 0 is copied unchanged. Every later line k gives a blend of lines k-1 and k, with A equal to the start phase (32 averages the two lines).
- R7: With `cfg_mirror` high, the pixels of each output line come out in reverse column order. Each mirrored line is emitted during the next input line, and the output whose newest line is the last line of the frame never appears.
- R8: Pixels beyond `cfg_len` in a line are dropped. Any such pixel sets `err_trunc`, which stays high until the next start of frame clears it.
- R9: `out_sol` marks the first pixel of each output line. `out_sof` marks only the first pixel of a frame's first output line.
- R10: Input before the first start of frame after reset produces no output.
- R11: In non-mirror mode, an output pixel appears one cycle after the input pixel that produced it. Idle input cycles give idle output cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame (also starts a line) |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | 8 | Input pixel |
| cfg_incr | input | INCR_W | Phase step per output line, 1/1024-line units; 0 selects the fixed modes |
| cfg_start | input | 7 | Start phase, 0 to 64, in 1/64-line units |
| cfg_mirror | input | 1 | Reverse pixel order of output lines |
| cfg_len | input | $clog2(MAX_LEN+1) | Pixels per line, 1 to MAX_LEN |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | First pixel of a frame's first output line |
| out_sol | output | 1 | First pixel of an output line |
| out_pix | output | 8 | Output pixel |
| err_trunc | output | 1 | Sticky flag for input lines longer than `cfg_len` |

## Verification
The bench builds the block with MAX_LEN=16 and LINE_W=8, which keeps the line stores small. Short lines let every mode run in a few hundred cycles. These include several start phases, steps of 1200 and 1536, both mirrored modes, truncation of over-long lines and gaps in the input stream. The reversed read address can then be checked at each column, and the wraparound of the three-bank rotation is exercised many times within one frame.

// File: rtl/vlerp_pkg.sv
package vlerp_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 10;
  localparam int WT_W   = 7;
  localparam int WT_SH  = 6;
  localparam int ACC_W  = PIX_W + WT_W + 1;
  localparam int NBANK  = 3;
  localparam logic [WT_W-1:0] WT_FULL = 7'd64;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [1:0]       bank_t;

  typedef struct packed {
    logic            emit;
    logic [WT_W-1:0] wt;
  } pick_t;

  function automatic pix_t mix(input pix_t p0, input pix_t p1, input logic [WT_W-1:0] a);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sh;
    acc = ACC_W'(a) * ACC_W'(p1)
        + (ACC_W'(WT_FULL) - ACC_W'(a)) * ACC_W'(p0)
        + ACC_W'(32);
    sh = acc >> WT_SH;
    return (sh > ACC_W'({PIX_W{1'b1}})) ? {PIX_W{1'b1}} : sh[PIX_W-1:0];
  endfunction

  function automatic bank_t nxt3(input bank_t b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

  function automatic bank_t prv3(input bank_t b);
    return (b == 2'd0) ? 2'd2 : b - 2'd1;
  endfunction
endpackage

// File: rtl/vlerp_linestore.sv
module vlerp_linestore
  import vlerp_pkg::*;
#(
  parameter int DEPTH = 384,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  pix_t          wdata,
  input  logic [AW-1:0] raddr,
  output pix_t          rdata
);
  pix_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vlerp_phase.sv
module vlerp_phase
  import vlerp_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int INCR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic [INCR_W-1:0] cfg_incr,
  input  logic [WT_W-1:0]   cfg_start,
  output pick_t             cur_pick,
  output pick_t             old_pick
);
  localparam int P_W = LINE_W + FRAC_W;

  logic [LINE_W-1:0] line_q, line_d, line_eff;
  logic [P_W-1:0]    pos_q, pos_d, pos_eff;
  pick_t             cur_q, cur_d, prev_q, prev_d, fresh;
  logic              zero_inc;

  always_comb begin
    zero_inc = (cfg_incr == '0);
    line_eff = restart ? '0 : (line_q + LINE_W'(1));
    pos_eff  = restart ? (P_W'(cfg_start) << 4) : pos_q;
    if (zero_inc) begin
      fresh.emit = 1'b1;
      fresh.wt   = (line_eff == '0) ? WT_FULL : cfg_start;
    end else begin
      fresh.emit = (line_eff != '0) &&
                   (pos_eff[P_W-1:FRAC_W] == (line_eff - LINE_W'(1)));
      fresh.wt   = {1'b0, pos_eff[FRAC_W-1:4]};
    end
    line_d = line_q;
    pos_d  = pos_q;
    cur_d  = cur_q;
    prev_d = prev_q;
    if (step) begin
      line_d = line_eff;
      pos_d  = (fresh.emit && !zero_inc) ? pos_eff + P_W'(cfg_incr) : pos_eff;
      cur_d  = fresh;
      prev_d = restart ? '0 : cur_q;
    end
    cur_pick = step ? fresh : cur_q;
    old_pick = restart ? '0 : (step ? cur_q : prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pos_q  <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      line_q <= line_d;
      pos_q  <= pos_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  // R3
  pos_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart) |=> (pos_q >= $past(pos_q)));
endmodule

// File: rtl/vlerp_mixout.sv
module vlerp_mixout
  import vlerp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emit,
  input  logic            sol,
  input  logic            sof,
  input  pix_t            p0,
  input  pix_t            p1,
  input  logic [WT_W-1:0] wt,
  output logic            out_valid,
  output logic            out_sol,
  output logic            out_sof,
  output pix_t            out_pix
);
  logic v_d, sol_d, sof_d;
  pix_t pix_d;

  always_comb begin
    v_d   = emit;
    sol_d = emit && sol;
    sof_d = emit && sof;
    pix_d = emit ? mix(p0, p1, wt) : out_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v_d;
      out_sol   <= sol_d;
      out_sof   <= sof_d;
      out_pix   <= pix_d;
    end
  end

  // R9
  sof_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_sol);
  // R9
  sol_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> out_valid);
endmodule

// File: rtl/vlerp_scaler.sv
module vlerp_scaler
  import vlerp_pkg::*;
#(
  parameter int MAX_LEN = 384,
  parameter int LINE_W  = 12,
  parameter int INCR_W  = 13,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic [7:0]        in_pix,
  input  logic [INCR_W-1:0] cfg_incr,
  input  logic [6:0]        cfg_start,
  input  logic              cfg_mirror,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_sol,
  output logic [7:0]        out_pix,
  output logic              err_trunc
);
  localparam int AW = $clog2(MAX_LEN);

  logic             acc_beat, sol_beat, restart, keep, emit, pend_eff;
  logic [LEN_W-1:0] col_q, col_d, col_eff;
  bank_t            bank_q, bank_d, b_cur, b_m1, b_m2;
  logic             frame_q, frame_d, pend_q, pend_d, err_q, err_d;
  logic [AW-1:0]    raddr;
  pix_t             rd [NBANK];
  pix_t             p1_sel, p0_raw, p0_sel;
  pick_t            cur_pick, old_pick, use_pick;

  always_comb begin
    acc_beat = in_valid && (frame_q || in_sof);
    sol_beat = acc_beat && (in_sol || in_sof);
    restart  = acc_beat && in_sof;
    col_eff  = sol_beat ? '0 : col_q;
    keep     = acc_beat && (col_eff < cfg_len);
    b_cur    = restart ? 2'd0 : (sol_beat ? nxt3(bank_q) : bank_q);
    b_m1     = prv3(b_cur);
    b_m2     = prv3(b_m1);
    raddr    = cfg_mirror ? AW'(cfg_len - LEN_W'(1) - col_eff) : AW'(col_eff);
    use_pick = cfg_mirror ? old_pick : cur_pick;
    p1_sel   = cfg_mirror ? rd[b_m1] : in_pix;
    p0_raw   = cfg_mirror ? rd[b_m2] : rd[b_m1];
    p0_sel   = (use_pick.wt == WT_FULL) ? '0 : p0_raw;
    emit     = keep && use_pick.emit;
    pend_eff = restart || pend_q;

    col_d = col_q;
    if (keep) col_d = col_eff + LEN_W'(1);
    else if (sol_beat) col_d = '0;
    bank_d  = b_cur;
    frame_d = frame_q || restart;
    pend_d  = acc_beat ? (pend_eff && !emit) : pend_q;
    err_d   = err_q;
    if (restart) err_d = 1'b0;
    else if (acc_beat && !keep) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      bank_q  <= '0;
      frame_q <= 1'b0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      col_q   <= col_d;
      bank_q  <= bank_d;
      frame_q <= frame_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
    end
  end

  assign err_trunc = err_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vlerp_linestore #(.DEPTH(MAX_LEN), .AW(AW)) u_store (
      .clk   (clk),
      .we    (keep && (b_cur == bank_t'(b))),
      .waddr (col_eff[AW-1:0]),
      .wdata (in_pix),
      .raddr (raddr),
      .rdata (rd[b])
    );
  end

  vlerp_phase #(.LINE_W(LINE_W), .INCR_W(INCR_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (sol_beat),
    .restart   (restart),
    .cfg_incr  (cfg_incr),
    .cfg_start (cfg_start),
    .cur_pick  (cur_pick),
    .old_pick  (old_pick)
  );

  vlerp_mixout u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (emit),
    .sol       (col_eff == '0),
    .sof       (pend_eff),
    .p0        (p0_sel),
    .p1        (p1_sel),
    .wt        (use_pick.wt),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_sof   (out_sof),
    .out_pix   (out_pix)
  );

  // R10
  no_prefrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_q && !(in_valid && in_sof)) |=> !out_valid);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(in_valid && in_sof)) |=> err_q);
  // R8
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(in_valid));
endmodule

// File: tb/vlerp_scaler_test.sv
module vlerp_scaler_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 16;
  localparam int LINE_W  = 8;
  localparam int INCR_W  = 13;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [7:0] in_pix = '0;
  logic [INCR_W-1:0] cfg_incr = '0;
  logic [6:0] cfg_start = 7'd64;
  logic cfg_mirror = 1'b0;
  logic [LEN_W-1:0] cfg_len = LEN_W'(4);
  logic out_valid, out_sof, out_sol, err_trunc;
  logic [7:0] out_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlerp_scaler #(.MAX_LEN(MAX_LEN), .LINE_W(LINE_W), .INCR_W(INCR_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .in_pix(in_pix), .cfg_incr(cfg_incr), .cfg_start(cfg_start), .cfg_mirror(cfg_mirror),
    .cfg_len(cfg_len), .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
    .out_pix(out_pix), .err_trunc(err_trunc));

  int checks = 0;
  int fails = 0;
  logic [7:0] img [16][16];
  int expv [32][16];
  int exp_n;
  int gotv [512][16];
  int got_len [512];
  bit got_sof [512];
  int got_n = 0;
  int cur = -1;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_sol && got_n < 512) begin
        cur = got_n;
        got_n++;
        got_len[cur] = 0;
        got_sof[cur] = out_sof;
      end
      if (cur >= 0 && got_len[cur] < 16) begin
        gotv[cur][got_len[cur]] = int'(out_pix);
        got_len[cur]++;
      end
    end
  end

  task automatic chk(input string req, input bit ok, input string what, input int act, input int expct);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expct);
    end
  endtask

  function automatic int bmix(input int p0, input int p1, input int a);
    return (a * p1 + (64 - a) * p0 + 32) >> 6;
  endfunction

  task automatic fill_img(input int seed);
    for (int l = 0; l < 16; l++)
      for (int j = 0; j < 16; j++)
        img[l][j] = 8'((l * 37 + j * 11 + seed * 53 + (((l + j) % 3 == 0) ? 128 : 0)) & 255);
  endtask

  task automatic build_exp(input int n, input int len, input int incr, input int yp, input bit mir);
    exp_n = 0;
    if (incr == 0) begin
      for (int k = 0; k < n; k++) begin
        if (mir && k == n - 1) break;
        for (int j = 0; j < len; j++) begin
          int src;
          src = mir ? len - 1 - j : j;
          expv[exp_n][j] = (k == 0) ? int'(img[0][src])
                                    : bmix(int'(img[k-1][src]), int'(img[k][src]), yp);
        end
        exp_n++;
      end
    end else begin
      for (int m = 0; m < 32; m++) begin
        int pos, i, a;
        pos = yp * 16 + m * incr;
        i = pos >> 10;
        a = (pos >> 4) & 63;
        if (i + 1 >= n) break;
        if (mir && i + 1 == n - 1) break;
        for (int j = 0; j < len; j++) begin
          int src;
          src = mir ? len - 1 - j : j;
          expv[exp_n][j] = bmix(int'(img[i][src]), int'(img[i+1][src]), a);
        end
        exp_n++;
      end
    end
  endtask

  task automatic send_frame(input int n, input int nsend, input bit gap);
    for (int l = 0; l < n; l++) begin
      for (int j = 0; j < nsend; j++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sof = (l == 0 && j == 0);
        in_sol = (j == 0);
        in_pix = img[l][j];
        if (gap && (j % 3 == 1)) begin
          @(negedge clk);
          in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(input string req, input int base, input int len);
    chk(req, (got_n - base) == exp_n, "output line count", got_n - base, exp_n);
    for (int m = 0; m < exp_n; m++) begin
      if (base + m >= got_n) break;
      chk(req, got_len[base+m] == len, $sformatf("line %0d length", m), got_len[base+m], len);
      for (int j = 0; j < len; j++)
        chk(req, gotv[base+m][j] == expv[m][j], $sformatf("line %0d pix %0d", m, j),
            gotv[base+m][j], expv[m][j]);
    end
    if (exp_n > 0 && got_n > base) begin
      int extra;
      extra = 0;
      for (int m = 1; m < got_n - base; m++) if (got_sof[base+m]) extra++;
      chk("R9", got_sof[base] == 1'b1, "sof on first output line", int'(got_sof[base]), 1);
      chk("R9", extra == 0, "sof on later lines", extra, 0);
    end
  endtask

  task automatic run_case(input string req, input int seed, input int n, input int len,
                          input int incr, input int yp, input bit mir, input bit gap);
    int base;
    cfg_incr = INCR_W'(incr); cfg_start = 7'(yp); cfg_mirror = mir; cfg_len = LEN_W'(len);
    fill_img(seed);
    build_exp(n, len, incr, yp, mir);
    base = got_n;
    send_frame(n, len, gap);
    compare(req, base, len);
  endtask

  task automatic t_reset;
    chk("R1", out_valid == 1'b0, "out_valid after reset", int'(out_valid), 0);
    chk("R1", out_sol == 1'b0 && out_sof == 1'b0, "markers after reset", int'(out_sol), 0);
    chk("R1", err_trunc == 1'b0, "err_trunc after reset", int'(err_trunc), 0);
  endtask

  task automatic t_presof;
    int base, seen;
    base = got_n; seen = 0;
    cfg_incr = '0; cfg_start = 7'd64; cfg_mirror = 1'b0; cfg_len = LEN_W'(4);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      if (out_valid) seen++;
      in_valid = 1'b1; in_sof = 1'b0; in_sol = (j == 0); in_pix = 8'(j + 7);
    end
    @(negedge clk);
    if (out_valid) seen++;
    in_valid = 1'b0; in_sol = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", seen == 0 && got_n == base, "output before first sof", seen, 0);
  endtask

  task automatic t_latency;
    cfg_incr = '0; cfg_start = 7'd64; cfg_mirror = 1'b0; cfg_len = LEN_W'(3);
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_sol = 1'b1; in_pix = 8'd91;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
    chk("R11", out_valid == 1'b1 && out_pix == 8'd91, "pixel one cycle later", int'(out_pix), 91);
    @(negedge clk);
    chk("R11", out_valid == 1'b0, "idle input gives idle output", int'(out_valid), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_round;
    int base;
    cfg_incr = '0; cfg_start = 7'd32; cfg_mirror = 1'b0; cfg_len = LEN_W'(4);
    for (int j = 0; j < 16; j++) begin
      img[0][j] = 8'd0; img[1][j] = 8'd1; img[2][j] = 8'd255; img[3][j] = 8'd0;
    end
    build_exp(4, 4, 0, 32, 1'b0);
    base = got_n;
    send_frame(4, 4, 1'b0);
    compare("R2", base, 4);
    chk("R2", gotv[base+1][0] == 1, "rounding 0/1 at A=32", gotv[base+1][0], 1);
    chk("R2", gotv[base+2][0] == 128, "average 1/255 at A=32", gotv[base+2][0], 128);
  endtask

  task automatic t_trunc;
    int base;
    cfg_incr = '0; cfg_start = 7'd64; cfg_mirror = 1'b0; cfg_len = LEN_W'(4);
    fill_img(5);
    build_exp(3, 4, 0, 64, 1'b0);
    base = got_n;
    chk("R8", err_trunc == 1'b0, "flag clear before long lines", int'(err_trunc), 0);
    send_frame(3, 6, 1'b0);
    compare("R8", base, 4);
    chk("R8", err_trunc == 1'b1, "flag set by long line", int'(err_trunc), 1);
    repeat (5) @(negedge clk);
    chk("R8", err_trunc == 1'b1, "flag held until next frame", int'(err_trunc), 1);
    run_case("R8", 6, 3, 4, 0, 64, 1'b0, 1'b0);
    chk("R8", err_trunc == 1'b0, "flag cleared by new frame", int'(err_trunc), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_presof();
    t_latency();
    run_case("R5", 1, 5, 6, 0, 64, 1'b0, 1'b0);
    run_case("R6", 2, 5, 6, 0, 32, 1'b0, 1'b0);
    run_case("R6", 3, 4, 5, 0, 16, 1'b0, 1'b1);
    t_round();
    run_case("R3", 4, 7, 5, 1536, 0, 1'b0, 1'b1);
    run_case("R4", 7, 6, 6, 1200, 64, 1'b0, 1'b0);
    run_case("R4", 8, 6, 4, 2048, 0, 1'b0, 1'b0);
    run_case("R7", 9, 4, 5, 0, 64, 1'b1, 1'b0);
    run_case("R7", 10, 7, 6, 1536, 16, 1'b1, 1'b1);
    run_case("R7", 11, 5, 7, 0, 40, 1'b1, 1'b0);
    t_trunc();
    run_case("R11", 12, 5, 8, 1100, 8, 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule